// File: doc/BRIEF.md
# Memory Tag Check Unit

This unit judges every load and store against the tag held in memory for the chunk it addresses. Each request brings its address, whose top bits carry the pointer tag, a flag from the first-stage translation saying whether the page is tagged, and the valid bit and value of the stored chunk tag. The unit holds a small configuration word for each lower privilege level. It gives one of four verdicts per request: pass, check elided, synchronous software-check fault, or deferred store fault.

Each level's configuration has three fields. A two-bit mode field turns tagging off (value zero) or picks the pointer tag width. A deferral bit lets store mismatches be logged instead of trapped. A zero-tag bypass bit lets a pointer whose tag is zero skip every check. Deferred store faults raise a sticky pending flag and capture the faulting address. Software drops the flag with a one-cycle clear pulse. Every fault verdict carries trap value 4.

Top module: `mtag_check_unit`

## Requirements
- R1: After a synchronous active-low reset, res_valid and async_pend are 0 and every level's configuration is zero, so tagging is off.
- R2: When the level's mode field is 00, or req_page_tagged is 0, the verdict is pass (res_code 0) with res_tval 0.
- R3: Mode values 01, 10 and 11 select pointer tag widths of 3, 4 and 5 bits. The pointer tag is the top bits of req_addr, and only that many low bits of req_mtag are compared.
- R4: With the bypass bit set and a pointer tag of zero, a tagged-page access is elided (res_code 1), even when the stored tag is invalid.
- R5: With the bypass bit clear, a zero pointer tag is checked like any other value.
- R6: An invalid stored tag gives a synchronous fault (res_code 2) with res_tval 4. This holds for stores too, whatever the deferral bit.
- R7: A valid stored tag that differs from the pointer tag gives a synchronous fault (res_code 2, res_tval 4) for loads, and for stores when the deferral bit is clear.
- R8: A store mismatch with the deferral bit set gives res_code 3 with res_tval 4. It sets async_pend and captures req_addr into async_addr.
- R9: async_pend is sticky and keeps the first captured address until an async_clr pulse clears it. A deferred fault in the same cycle as async_clr wins: the flag stays set and the new address is captured.
- R10: A verdict appears on res_valid exactly one cycle after req_valid, and res_valid is 0 in every other cycle.
- R11: cfg_wdata bit layout for the level picked by cfg_lvl: [3:2] mode, [4] deferral, [5] bypass. Bits [1:0] belong to the address-masking field and are ignored, as are bits above 5. A request uses the configuration of its own req_lvl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lvl | input | LVL_W | Level whose configuration is written |
| cfg_wdata | input | CFG_W | Configuration word |
| req_valid | input | 1 | Request strobe |
| req_lvl | input | LVL_W | Privilege level of the access |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | ADDR_W | Access address; top bits hold the pointer tag |
| req_page_tagged | input | 1 | Page is marked tagged |
| req_mtag_valid | input | 1 | Stored chunk tag is valid |
| req_mtag | input | TAG_MAX | Stored chunk tag |
| async_clr | input | 1 | Clears the pending deferred fault |
| res_valid | output | 1 | Verdict valid |
| res_code | output | 2 | 0 pass, 1 elided, 2 sync fault, 3 deferred fault |
| res_tval | output | TVAL_W | Trap value, 4 on faults, else 0 |
| async_pend | output | 1 | Deferred store fault pending |
| async_addr | output | ADDR_W | Address of the captured deferred fault |

## Verification
A deferred store fault and the software clear pulse can land in the same cycle. The bench provokes this by issuing a mismatching store at a deferral-enabled level while async_clr is high and an older fault is already pending. It then judges that async_pend stays 1 and that async_addr now holds the new store's address, not the old one. A clear alone must drop the flag. A second fault without a clear must leave the first address in place.

// File: rtl/mtag_pkg.sv
// Shared types for the memory tag check unit.
// Assumes: verdict codes are fixed at 2 bits; field positions are fixed by the config word layout.
package mtag_pkg;

    typedef enum logic [1:0] {
        RES_PASS   = 2'd0,
        RES_ELIDED = 2'd1,
        RES_SYNC   = 2'd2,
        RES_ASYNC  = 2'd3
    } res_code_e;

    typedef struct packed {
        logic       zero_bypass;
        logic       defer_st;
        logic [1:0] tmode;
    } lvl_cfg_t;

    localparam int FLD_MODE_LO = 2;
    localparam int FLD_DEFER   = 4;
    localparam int FLD_BYPASS  = 5;

endpackage

// File: rtl/mtag_cfg_bank.sv
// Holds one configuration entry per privilege level.
// Assumes: one write per cycle; bits outside the three fields are dropped.
module mtag_cfg_bank
    import mtag_pkg::*;
#(
    parameter int NUM_LVL = 2,
    parameter int LVL_W   = 1,
    parameter int CFG_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [LVL_W-1:0]        wlvl,
    input  logic [CFG_W-1:0]        wdata,
    output lvl_cfg_t [NUM_LVL-1:0]  cfg_all
);

    logic unused_wbits;
    // Other fields of the shared word are not consumed here
    assign unused_wbits = ^{wdata[CFG_W-1:FLD_BYPASS+1], wdata[FLD_MODE_LO-1:0]};

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        // Per-level field register, written when the level is selected
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_all[g] <= '0;
            end else if (we && (int'(wlvl) == g)) begin
                cfg_all[g].tmode       <= wdata[FLD_MODE_LO+1:FLD_MODE_LO];
                cfg_all[g].defer_st    <= wdata[FLD_DEFER];
                cfg_all[g].zero_bypass <= wdata[FLD_BYPASS];
            end
        end
    end

endmodule

// File: rtl/mtag_decide.sv
// Combinational verdict for one access from its level configuration.
// Assumes: tag width is TAG_BASE_W + mode - 1 for nonzero modes.
module mtag_decide
    import mtag_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int TAG_BASE_W = 3,
    parameter int TAG_MAX    = 5
) (
    input  lvl_cfg_t            cfg,
    input  logic                is_store,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                page_tagged,
    input  logic                mtag_valid,
    input  logic [TAG_MAX-1:0]  mtag,
    output res_code_e           code
);

    int                 w;
    logic [TAG_MAX-1:0] mask;
    logic [TAG_MAX-1:0] ptr;

    // Extract the pointer tag from the top address bits and build the compare mask
    always_comb begin
        w = TAG_BASE_W + int'(cfg.tmode) - 1;
        for (int i = 0; i < TAG_MAX; i++) begin
            mask[i] = (i < w);
            ptr[i]  = (i < w) ? addr[ADDR_W - w + i] : 1'b0;
        end
    end

    // Pick the verdict: off/untagged, bypass, invalid, mismatch
    always_comb begin
        code = RES_PASS;
        if (cfg.tmode != 2'b00 && page_tagged) begin
            if (cfg.zero_bypass && ptr == '0) begin
                code = RES_ELIDED;
            end else if (!mtag_valid) begin
                code = RES_SYNC;
            end else if ((mtag & mask) != ptr) begin
                code = (is_store && cfg.defer_st) ? RES_ASYNC : RES_SYNC;
            end
        end
    end

endmodule

// File: rtl/mtag_async_log.sv
// Sticky record of a deferred store fault and its address.
// Assumes: a new fault in a clear cycle takes priority over the clear.
module mtag_async_log #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [ADDR_W-1:0] hit_addr,
    input  logic              clr,
    output logic              pend,
    output logic [ADDR_W-1:0] pend_addr
);

    // Set on fault (first address kept unless cleared), drop on clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_addr <= '0;
        end else if (hit) begin
            pend <= 1'b1;
            if (!pend || clr) pend_addr <= hit_addr;
        end else if (clr) begin
            pend <= 1'b0;
        end
    end

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !clr |=> pend && $stable(pend_addr)); // R9
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !hit |=> !pend); // R9

endmodule

// File: rtl/mtag_check_unit.sv
// Memory tag check unit: per-level configuration, verdict, registered result
// and deferred store fault log.
// Assumes: one request per cycle; result is registered one cycle later.
module mtag_check_unit
    import mtag_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NUM_LVL    = 2,
    parameter int CFG_W      = 8,
    parameter int TAG_BASE_W = 3,
    parameter int TVAL_W     = 8,
    parameter int TVAL_TAG   = 4,
    localparam int LVL_W     = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
    localparam int TAG_MAX   = TAG_BASE_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [LVL_W-1:0]   cfg_lvl,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               req_valid,
    input  logic [LVL_W-1:0]   req_lvl,
    input  logic               req_store,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_page_tagged,
    input  logic               req_mtag_valid,
    input  logic [TAG_MAX-1:0] req_mtag,
    input  logic               async_clr,
    output logic               res_valid,
    output logic [1:0]         res_code,
    output logic [TVAL_W-1:0]  res_tval,
    output logic               async_pend,
    output logic [ADDR_W-1:0]  async_addr
);

    lvl_cfg_t [NUM_LVL-1:0] cfg_all;
    lvl_cfg_t               cur_cfg;
    res_code_e              code;

    mtag_cfg_bank #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wlvl(cfg_lvl),
        .wdata(cfg_wdata), .cfg_all(cfg_all)
    );

    // Select the requesting level's configuration
    always_comb begin
        cur_cfg = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (int'(req_lvl) == i) cur_cfg = cfg_all[i];
        end
    end

    mtag_decide #(.ADDR_W(ADDR_W), .TAG_BASE_W(TAG_BASE_W), .TAG_MAX(TAG_MAX)) u_dec (
        .cfg(cur_cfg), .is_store(req_store), .addr(req_addr),
        .page_tagged(req_page_tagged), .mtag_valid(req_mtag_valid),
        .mtag(req_mtag), .code(code)
    );

    mtag_async_log #(.ADDR_W(ADDR_W)) u_log (
        .clk(clk), .rst_n(rst_n), .hit(req_valid && code == RES_ASYNC),
        .hit_addr(req_addr), .clr(async_clr),
        .pend(async_pend), .pend_addr(async_addr)
    );

    // Register the verdict and its trap value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_code  <= RES_PASS;
            res_tval  <= '0;
        end else begin
            res_valid <= req_valid;
            res_code  <= code;
            res_tval  <= (code == RES_SYNC || code == RES_ASYNC) ? TVAL_W'(TVAL_TAG) : '0;
        end
    end

    AST_RES_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid); // R10
    AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid); // R10
    AST_FAULT_TVAL: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_code[1] |-> res_tval == TVAL_W'(TVAL_TAG)); // R6
    AST_OK_TVAL: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_code[1] |-> res_tval == '0); // R2
    AST_DEFER_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_code == RES_ASYNC |-> async_pend); // R8
    AST_DEFER_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_code == RES_ASYNC |-> $past(req_store)); // R8

endmodule

// File: tb/mtag_check_unit_test.sv
module mtag_check_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_lvl = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [0:0]  req_lvl = '0;
    logic        req_store = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_page_tagged = 1'b0;
    logic        req_mtag_valid = 1'b0;
    logic [4:0]  req_mtag = '0;
    logic        async_clr = 1'b0;
    logic        res_valid;
    logic [1:0]  res_code;
    logic [7:0]  res_tval;
    logic        async_pend;
    logic [15:0] async_addr;

    int total = 0;
    int bad = 0;

    typedef struct { logic [1:0] code; string req; } exp_t;
    exp_t exp_q[$];

    logic [1:0] m_mode [2];
    logic       m_defer [2];
    logic       m_bypass [2];

    always #2.5 clk = ~clk;

    mtag_check_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lvl(cfg_lvl),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_lvl(req_lvl),
        .req_store(req_store), .req_addr(req_addr),
        .req_page_tagged(req_page_tagged), .req_mtag_valid(req_mtag_valid),
        .req_mtag(req_mtag), .async_clr(async_clr), .res_valid(res_valid),
        .res_code(res_code), .res_tval(res_tval), .async_pend(async_pend),
        .async_addr(async_addr)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [1:0] model(input int lvl, input bit st, input logic [15:0] a,
                                         input bit tg, input bit mv, input logic [4:0] mt);
        int w;
        logic [4:0] ptr;
        logic [4:0] msk;
        if (m_mode[lvl] == 2'b00 || !tg) return 2'd0;
        w   = 2 + int'(m_mode[lvl]);
        ptr = 5'(a >> (16 - w));
        msk = 5'((1 << w) - 1);
        if (m_bypass[lvl] && ptr == 5'd0) return 2'd1;
        if (!mv) return 2'd2;
        if ((mt & msk) != ptr) return (st && m_defer[lvl]) ? 2'd3 : 2'd2;
        return 2'd0;
    endfunction

    // Driver: present one request for one cycle and queue its expected verdict
    task automatic issue(input int lvl, input bit st, input logic [15:0] a, input bit tg,
                         input bit mv, input logic [4:0] mt, input bit clr, input string req);
        exp_t e;
        e.code = model(lvl, st, a, tg, mv, mt);
        e.req  = req;
        exp_q.push_back(e);
        req_valid = 1'b1; req_lvl = 1'(lvl); req_store = st; req_addr = a;
        req_page_tagged = tg; req_mtag_valid = mv; req_mtag = mt; async_clr = clr;
        @(posedge clk); #1;
        req_valid = 1'b0; async_clr = 1'b0;
    endtask

    task automatic write_cfg(input int lvl, input logic [7:0] d);
        cfg_we = 1'b1; cfg_lvl = 1'(lvl); cfg_wdata = d;
        m_mode[lvl] = d[3:2]; m_defer[lvl] = d[4]; m_bypass[lvl] = d[5]; // R11 layout
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: pop expected verdict on each result and compare
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(res_code == e.code, e.req, int'(res_code), int'(e.code));
                check(res_tval == ((e.code >= 2) ? 8'd4 : 8'd0), {e.req, " tval"},
                      int'(res_tval), (e.code >= 2) ? 4 : 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin m_mode[i] = 2'b00; m_defer[i] = 1'b0; m_bypass[i] = 1'b0; end
        idle(3);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);
        check(async_pend == 1'b0, "R1 async_pend", int'(async_pend), 0);
        // R1/R2: configuration is off after reset, so a mismatch passes
        issue(0, 1'b0, 16'hE000, 1'b1, 1'b1, 5'd1, 1'b0, "R1 disabled after reset");
        // R11: level 0 mode 01 only, stray bits set; level 1 mode 11 with defer and bypass
        write_cfg(0, 8'b1100_0111);
        write_cfg(1, 8'b0011_1111);
        // R2: untagged page passes despite mismatch
        issue(1, 1'b1, 16'hA800, 1'b0, 1'b1, 5'd0, 1'b0, "R2 untagged page");
        // R3: width 3 compares low 3 bits only (top3=101, tag 11101)
        issue(0, 1'b0, 16'hA000, 1'b1, 1'b1, 5'b11101, 1'b0, "R3 width3 match");
        // R3: width 5 sees the difference in bit 3
        issue(1, 1'b0, 16'hA800, 1'b1, 1'b1, 5'b11101, 1'b0, "R3 width5 mismatch");
        issue(1, 1'b0, 16'hE800, 1'b1, 1'b1, 5'b11101, 1'b0, "R3 width5 match");
        // R4: bypass with zero tag, invalid stored tag, load and store
        issue(1, 1'b0, 16'h0123, 1'b1, 1'b0, 5'd7, 1'b0, "R4 elide load");
        issue(1, 1'b1, 16'h0456, 1'b1, 1'b1, 5'd9, 1'b0, "R4 elide store");
        // R5: bypass off, zero tag still checked
        issue(0, 1'b0, 16'h0100, 1'b1, 1'b1, 5'd0, 1'b0, "R5 zero tag match");
        issue(0, 1'b0, 16'h0100, 1'b1, 1'b0, 5'd0, 1'b0, "R5 zero tag invalid");
        issue(0, 1'b0, 16'h0100, 1'b1, 1'b1, 5'd2, 1'b0, "R5 zero tag mismatch");
        // R6: invalid stored tag on a deferral-enabled store stays synchronous
        issue(1, 1'b1, 16'h8800, 1'b1, 1'b0, 5'b10001, 1'b0, "R6 invalid store");
        check(async_pend == 1'b0, "R6 no pending", int'(async_pend), 0);
        // R7: load mismatch and non-deferred store mismatch
        issue(1, 1'b0, 16'h8800, 1'b1, 1'b1, 5'd3, 1'b0, "R7 load mismatch");
        issue(0, 1'b1, 16'h6000, 1'b1, 1'b1, 5'd1, 1'b0, "R7 store mismatch no defer");
        // R3: mode 10 gives width 4
        write_cfg(0, 8'b0000_1000);
        issue(0, 1'b0, 16'hB000, 1'b1, 1'b1, 5'b11011, 1'b0, "R3 width4 match");
        issue(0, 1'b0, 16'hB000, 1'b1, 1'b1, 5'b11010, 1'b0, "R3 width4 mismatch");
        // R8: deferred store fault
        issue(1, 1'b1, 16'h9A11, 1'b1, 1'b1, 5'd0, 1'b0, "R8 deferred fault");
        check(async_pend == 1'b1, "R8 pend set", int'(async_pend), 1);
        check(async_addr == 16'h9A11, "R8 addr", int'(async_addr), 16'h9A11);
        // R9: second fault keeps the first address
        issue(1, 1'b1, 16'h9B22, 1'b1, 1'b1, 5'd0, 1'b0, "R9 second fault");
        check(async_addr == 16'h9A11, "R9 first addr kept", int'(async_addr), 16'h9A11);
        // R9: fault and clear in the same cycle, fault wins
        issue(1, 1'b1, 16'h9C33, 1'b1, 1'b1, 5'd0, 1'b1, "R9 fault with clear");
        check(async_pend == 1'b1, "R9 pend held", int'(async_pend), 1);
        check(async_addr == 16'h9C33, "R9 new addr", int'(async_addr), 16'h9C33);
        // R9: clear alone drops the flag
        async_clr = 1'b1;
        idle(1);
        async_clr = 1'b0;
        check(async_pend == 1'b0, "R9 cleared", int'(async_pend), 0);
        // R10: idle cycles produce no result
        idle(1);
        check(res_valid == 1'b0, "R10 idle", int'(res_valid), 0);
        idle(3);
        check(exp_q.size() == 0, "R10 all results seen", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule